// File: doc/BRIEF.md
# UltraLogLog Sketch Register Update Unit

This block holds the register file of an UltraLogLog cardinality sketch: 2^P one-byte registers, where P is the compile-time precision. Each accepted beat carries one 64-bit hash. The top P bits of the hash select a register. The bits that remain, shifted up to the top of a 64-bit word, form the tail. The number of leading zeros in the tail, capped at 64-P, gives the bit position that the hash sets in that register's hash prefix.

A register byte stores a compressed 64-bit hash prefix. The upper six bits hold the position of the prefix's highest set bit. The lower two bits hold the two prefix bits just beneath it. An insert expands the byte to its prefix, ORs in the newly observed bit, and packs the result back. Any bits below the top three are lost in the pack.

Because the encoding is offset, a full register always reads 255 and the smallest nonzero value is 4P-4. A combinational read port exposes any register. A clear request zeroes the file one register per cycle while `ready_o` is low.

Top module: `ull_sketch`

## Requirements
- R1: The register index is `hash_i[63 -: P]`. An insert changes only the selected register.
- R2: For a tail `hash_i << P` with n leading zeros, where n is capped at 64-P for an all-zero tail, the observed bit position is n+P-1. A single insert into an empty register gives byte 4·(n+P-1). This ranges from 4P-4 up to 252 for an all-zero tail.
- R3: A nonzero register byte has the highest set prefix position in bits [7:2], the prefix bit one below it in bit 1, and the prefix bit two below it in bit 0. The value 0 means empty, and no nonzero value below 4P-4 appears.
- R4: The new value is pack(unpack(old) OR observed bit). An observed bit more than two positions below the leading one leaves the register unchanged, and register values never decrease.
- R5: Inserting the same hash again leaves the register unchanged.
- R6: A register whose leading one is at position 63 with both lower bits set reads 255 and stays 255 under any further insert.
- R7: An insert accepted on a rising edge is visible on `rd_data_o` after the following rising edge. Inserts to the same index on consecutive cycles all take effect.
- R8: A clear accepted with `ready_o` high zeroes every register. It holds `ready_o` low for exactly 2^P cycles, and `valid_i` is ignored while `ready_o` is low.
- R9: When `clear_i` and `valid_i` are high together, the clear wins and the insert is dropped. `clear_i` has no effect while a clear is in progress.
- R10: After reset all registers read 0 and `ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Hash beat valid |
| hash_i | input | 64 | Hash value to insert |
| clear_i | input | 1 | Request to empty the sketch |
| ready_o | output | 1 | High when inserts and clears are accepted |
| rd_idx_i | input | P | Register index for the read port |
| rd_data_o | output | 8 | Register byte at `rd_idx_i` |

## Verification
A corrupted register appears on the read port as soon as that index is selected. The checks are set up so that a wrong pack or unpack shows within two cycles of the insert that exposes it. Wrong mantissa bits stay in the register until a higher leading one overwrites them, so directed sequences climb through positions 61 to 63 and through spaced positions with gaps. Clear-length faults show as a wrong count of low `ready_o` cycles. Dropped or leaked inserts during a clear show as nonzero bytes once the clear is done.

// File: rtl/ull_pkg.sv
package ull_pkg;
  localparam int HASH_W = 64;
  localparam int POS_W  = 6;
  localparam int LZ_W   = 7;
  typedef logic [7:0]        ureg_t;
  typedef logic [POS_W-1:0]  pos_t;
endpackage

// File: rtl/ull_lzc.sv
module ull_lzc #(
  parameter int W = 64,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  in_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (in_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/ull_obs_pos.sv
module ull_obs_pos
  import ull_pkg::*;
#(
  parameter int P = 6
) (
  input  logic [HASH_W-1:0] hash_i,
  output pos_t              pos_o
);
  localparam logic [LZ_W-1:0] SAT  = LZ_W'(HASH_W - P);
  localparam logic [LZ_W-1:0] BIAS = LZ_W'(P - 1);

  logic [HASH_W-1:0] tail;
  logic [LZ_W-1:0]   lz, lz_sat, sum;

  assign tail = hash_i << P;

  ull_lzc #(.W(HASH_W)) u_lzc (.in_i(tail), .cnt_o(lz));

  assign lz_sat = (lz > SAT) ? SAT : lz;
  assign sum    = lz_sat + BIAS;
  assign pos_o  = sum[POS_W-1:0];
endmodule

// File: rtl/ull_reg_update.sv
module ull_reg_update
  import ull_pkg::*;
(
  input  ureg_t old_i,
  input  pos_t  pos_i,
  output ureg_t new_o
);
  pos_t              ex, sh, hi;
  logic [HASH_W-1:0] pfx_old, pfx_new, mant_src;
  logic [LZ_W-1:0]   lz, hi_w;
  logic [1:0]        mant;

  // unpack: implicit one above the two stored bits
  always_comb begin
    ex      = old_i[7:2];
    sh      = (ex >= pos_t'(2)) ? ex - pos_t'(2) : '0;
    pfx_old = (old_i == '0) ? '0 : (HASH_W'({1'b1, old_i[1:0]}) << sh);
    pfx_new = pfx_old | (HASH_W'(1) << pos_i);
  end

  ull_lzc #(.W(HASH_W)) u_lzc (.in_i(pfx_new), .cnt_o(lz));

  // pack: keep leading one and two bits below it
  always_comb begin
    hi_w     = LZ_W'(HASH_W - 1) - lz;
    hi       = hi_w[POS_W-1:0];
    mant_src = pfx_new >> (hi - pos_t'(2));
    mant     = (hi >= pos_t'(2)) ? mant_src[1:0] : 2'b00;
    new_o    = {hi, mant};
  end
endmodule

// File: rtl/ull_sketch.sv
module ull_sketch
  import ull_pkg::*;
#(
  parameter int P = 6,
  localparam int NREG = 1 << P
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [HASH_W-1:0] hash_i,
  input  logic              clear_i,
  output logic              ready_o,
  input  logic [P-1:0]      rd_idx_i,
  output logic [7:0]        rd_data_o
);
  ureg_t          regs [NREG];
  logic           s1_vld;
  logic [P-1:0]   s1_idx;
  pos_t           s1_pos, obs_pos;
  ureg_t          upd;
  logic           clr_busy;
  logic [P-1:0]   clr_cnt;
  logic           accept;

  assign ready_o   = ~clr_busy;
  assign accept    = valid_i & ready_o & ~clear_i;
  assign rd_data_o = regs[rd_idx_i];

  ull_obs_pos #(.P(P)) u_obs (.hash_i(hash_i), .pos_o(obs_pos));

  ull_reg_update u_upd (.old_i(regs[s1_idx]), .pos_i(s1_pos), .new_o(upd));

  // stage 1: capture index and observed bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld <= 1'b0;
      s1_idx <= '0;
      s1_pos <= '0;
    end else begin
      s1_vld <= accept;
      if (accept) begin
        s1_idx <= hash_i[HASH_W-1 -: P];
        s1_pos <= obs_pos;
      end
    end
  end

  // clear sequencer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_busy <= 1'b0;
      clr_cnt  <= '0;
    end else if (clr_busy) begin
      clr_cnt <= clr_cnt + 1'b1;
      if (clr_cnt == P'(NREG - 1)) clr_busy <= 1'b0;
    end else if (clear_i) begin
      clr_busy <= 1'b1;
      clr_cnt  <= '0;
    end
  end

  // stage 2: write back; s1 and clear never overlap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (clr_busy) begin
      regs[clr_cnt] <= '0;
    end else if (s1_vld) begin
      regs[s1_idx] <= upd;
    end
  end
endmodule

// File: rtl/ull_sketch_chk.sv
module ull_sketch_chk #(
  parameter int P = 6,
  localparam int NREG = 1 << P
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         clear_i,
  input logic         ready_o,
  input logic [P-1:0] rd_idx_i,
  input logic [7:0]   rd_data_o
);
  logic [P:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       low_cnt <= '0;
    else if (!ready_o) low_cnt <= low_cnt + 1'b1;
    else               low_cnt <= '0;
  end

  // R3: nonzero bytes never below the floor
  a_r3_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o != 8'd0) |-> (rd_data_o[7:2] >= 6'(P - 1)));

  // R4: a watched register never decreases outside a clear
  a_r4_monotone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && $past(ready_o) && $stable(rd_idx_i)) |-> (rd_data_o >= $past(rd_data_o)));

  // R8: accepted clear drops ready
  a_r8_clear_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && ready_o) |=> !ready_o);

  // R8: busy window is exactly NREG cycles
  a_r8_clear_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (low_cnt == (P+1)'(NREG)));

  // R9: clear during clear does not extend it
  a_r9_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (low_cnt < (P+1)'(NREG)));
endmodule

bind ull_sketch ull_sketch_chk #(.P(P)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .ready_o(ready_o),
  .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o)
);

// File: tb/sim_ull_sketch.sv
module sim_ull_sketch;
  localparam int P = 6;
  localparam int NREG = 1 << P;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [63:0]  hash_i = '0;
  logic         clear_i = 1'b0;
  logic         ready_o;
  logic [P-1:0] rd_idx_i = '0;
  logic [7:0]   rd_data_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl [NREG];

  always #10 clk_i = ~clk_i;

  ull_sketch #(.P(P)) u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int obs_pos(input logic [63:0] h);
    logic [63:0] t;
    int n;
    t = h << P;
    n = 0;
    while (n < 64 - P && t[63-n] == 1'b0) n++;
    return n + P - 1;
  endfunction

  function automatic logic [7:0] mdl_upd(input logic [7:0] old, input int pos);
    logic [63:0] pf;
    int e, h;
    pf = '0;
    if (old != 0) begin
      e = int'(old[7:2]);
      pf[e] = 1'b1;
      pf[e-1] = old[1];
      pf[e-2] = old[0];
    end
    pf[pos] = 1'b1;
    h = 63;
    while (!pf[h]) h--;
    return 8'(h * 4 + int'(pf[h-1]) * 2 + int'(pf[h-2]));
  endfunction

  function automatic logic [63:0] mk_hash(input int idx, input int pos, input logic [63:0] junk);
    logic [63:0] h;
    h = 64'(idx) << (64 - P);
    if (pos < 63) h = h | (64'd1 << (62 - pos)) | (junk & ((64'd1 << (62 - pos)) - 64'd1));
    return h;
  endfunction

  task automatic rd(input int idx, output int v);
    rd_idx_i = P'(idx);
    #1;
    v = int'(rd_data_o);
  endtask

  task automatic check_all(input string req);
    int v;
    int bad;
    bad = 0;
    for (int i = 0; i < NREG; i++) begin
      rd(i, v);
      if (v != int'(mdl[i])) begin
        if (bad == 0) chk(1'b0, req, v, int'(mdl[i]));
        bad++;
      end
    end
    if (bad == 0) chk(1'b1, req, 0, 0);
  endtask

  // one insert, then wait until it is visible (at negedge)
  task automatic ins(input logic [63:0] h);
    int idx;
    idx = int'(h[63 -: P]);
    valid_i = 1'b1;
    hash_i = h;
    @(posedge clk_i);
    @(negedge clk_i);
    valid_i = 1'b0;
    @(posedge clk_i);
    @(negedge clk_i);
    mdl[idx] = mdl_upd(mdl[idx], obs_pos(h));
  endtask

  task automatic ins_chk(input int idx, input int pos, input int exp, input string req);
    int v;
    ins(mk_hash(idx, pos, 64'h5a5a_a5a5_3c3c_c3c3));
    rd(idx, v);
    chk(v == exp && v == int'(mdl[idx]), req, v, exp);
  endtask

  task automatic t_reset();
    chk(ready_o == 1'b1, "R10 ready after reset", int'(ready_o), 1);
    check_all("R10 registers zero after reset");
  endtask

  task automatic t_index();
    ins_chk(5, P + 2, 4 * (P + 2), "R1 R2 index and position");
    check_all("R1 other registers untouched");
  endtask

  task automatic t_extremes();
    ins_chk(9, P - 1, 4 * P - 4, "R2 minimum position gives 4P-4");
    ins_chk(10, 63, 252, "R2 zero tail saturates at 63");
    ins_chk(10, 62, 254, "R3 bit one below leading one");
    ins_chk(10, 61, 255, "R6 reaches 255");
    ins_chk(10, 60, 255, "R6 stays 255");
  endtask

  task automatic t_discard();
    ins_chk(12, 10, 40, "R2 single insert pos 10");
    ins_chk(12, 20, 80, "R4 lower bits discarded");
    ins_chk(12, 18, 81, "R3 bit two below leading one");
    ins_chk(12, 10, 81, "R4 low observation no effect");
  endtask

  task automatic t_repeat();
    logic [63:0] h;
    int v1, v2;
    h = mk_hash(3, 33, 64'h1234_5678_9abc_def0);
    ins(h);
    rd(3, v1);
    ins(h);
    rd(3, v2);
    chk(v1 == v2 && v2 == 132, "R5 repeat insert unchanged", v2, 132);
  endtask

  task automatic t_latency();
    int v;
    valid_i = 1'b1;
    hash_i = mk_hash(20, 40, '0);
    @(posedge clk_i);
    @(negedge clk_i);
    valid_i = 1'b0;
    rd(20, v);
    chk(v == 0, "R7 not visible after first edge", v, 0);
    @(posedge clk_i);
    @(negedge clk_i);
    rd(20, v);
    chk(v == 160, "R7 visible after second edge", v, 160);
    mdl[20] = 8'd160;
  endtask

  task automatic t_b2b();
    int v;
    valid_i = 1'b1;
    hash_i = mk_hash(7, 30, '0);
    @(posedge clk_i);
    @(negedge clk_i);
    hash_i = mk_hash(7, 29, '0);
    @(posedge clk_i);
    @(negedge clk_i);
    hash_i = mk_hash(7, 28, '0);
    @(posedge clk_i);
    @(negedge clk_i);
    valid_i = 1'b0;
    @(posedge clk_i);
    @(negedge clk_i);
    rd(7, v);
    chk(v == 123, "R7 back-to-back same index", v, 123);
    mdl[7] = 8'd123;
  endtask

  task automatic t_stream();
    logic [63:0] h;
    valid_i = 1'b1;
    for (int k = 0; k < 300; k++) begin
      h = {$urandom, $urandom};
      if (k % 5 == 0) h[63 -: P] = P'(k % 3);
      if (k % 7 == 0) h[63-P:0] = '0;
      hash_i = h;
      mdl[int'(h[63 -: P])] = mdl_upd(mdl[int'(h[63 -: P])], obs_pos(h));
      @(posedge clk_i);
      @(negedge clk_i);
    end
    valid_i = 1'b0;
    @(posedge clk_i);
    @(negedge clk_i);
    check_all("R4 R7 random stream matches model");
  endtask

  task automatic t_clear();
    int cnt;
    clear_i = 1'b1;
    valid_i = 1'b1;
    hash_i = mk_hash(0, 50, '0);
    @(posedge clk_i);
    @(negedge clk_i);
    clear_i = 1'b0;
    chk(ready_o == 1'b0, "R8 ready low after clear", int'(ready_o), 0);
    cnt = 0;
    while (!ready_o && cnt < 4 * NREG) begin
      cnt++;
      if (cnt == NREG / 2) clear_i = 1'b1;
      if (cnt == NREG / 2 + 1) clear_i = 1'b0;
      @(negedge clk_i);
    end
    valid_i = 1'b0;
    clear_i = 1'b0;
    chk(cnt == NREG, "R8 R9 clear busy length", cnt, NREG);
    for (int i = 0; i < NREG; i++) mdl[i] = 8'd0;
    @(posedge clk_i);
    @(negedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i);
    chk(ready_o == 1'b1, "R9 no restart from clear during clear", int'(ready_o), 1);
    check_all("R8 R9 all zero, inserts dropped");
    ins_chk(0, 62, 248, "R8 insert works after clear");
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) mdl[i] = 8'd0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_index();
    t_extremes();
    t_discard();
    t_repeat();
    t_latency();
    t_b2b();
    t_stream();
    t_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule